// File: doc/BRIEF.md
# Triangle Batcher with Vertex Reuse

This block sits at the head of the geometry path. It takes the vertex indices of a triangle-list draw and packs the triangles into batches sized for one vertex-shading warp. An indexed draw supplies its indices over a valid/ready stream. A non-indexed draw is started with a single pulse that gives a first index and a triangle count. The block then produces the consecutive indices itself.

Within a batch each distinct vertex index is kept only once. A triangle therefore names its corners by batch-local slot numbers, and the shader never runs twice for the same vertex of that batch. A batch is closed when the next triangle would overflow its triangle budget or its vertex budget, so a triangle is never split. A batch is also closed when the draw ends. A closed batch goes to one of several processing clusters, chosen in round-robin order among those that signal ready. A batch goes out as a burst of words: first the unique vertex indices, then one word per triangle.

Top module: `prim_batcher`

## Requirements
- R1: Indices are taken from `idx_data` when `idx_valid` and `idx_ready` are both high. A `gen_start` pulse with a nonzero `gen_tris`, given while no generation runs, produces `3*gen_tris` indices `gen_first`, `gen_first+1`, … as one draw. During generation `idx_ready` is low and a further `gen_start` is ignored.
- R2: A batch never holds more than 32 triangles or more than 32 distinct vertex indices.
- R3: Each distinct index of a batch appears exactly once among its vertex words, in order of first appearance. Vertex word k is the index held in slot k.
- R4: Each triangle word carries three 5-bit slots: the first corner in bits [4:0], the second in [9:5] and the third in [14:10]. Each slot names the vertex word that holds that corner. Triangles keep their input order, and all three corners of a triangle are always in the same batch.
- R5: When the next triangle would push the distinct-vertex count above 32, or the batch already holds 32 triangles, the current batch is closed first. That triangle then opens the next batch.
- R6: The end of a draw (`idx_last` on an index, or the final generated index) flushes a nonempty batch. A batch with no triangles is never sent. Indices of an incomplete trailing triangle are discarded.
- R7: A batch is sent in consecutive cycles: all vertex words (`out_is_tri` low), then all triangle words (`out_is_tri` high). `out_last` is high on the final word only.
- R8: Each batch goes to one cluster, shown one-hot on `out_dest` and held for the whole batch. The cluster is the first ready one after the previously chosen cluster in circular order. After reset the search starts at cluster 0.
- R9: While a batch is closed and no cluster is ready, nothing is sent and no index is accepted.
- R10: After reset `out_valid` is low, `out_dest` is zero and `idx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_start | input | 1 | Starts a non-indexed draw |
| gen_first | input | IDX_W | First generated index |
| gen_tris | input | TRI_W | Triangle count of a generated draw |
| idx_valid | input | 1 | Index stream valid |
| idx_data | input | IDX_W | Vertex index |
| idx_last | input | 1 | Last index of the indexed draw |
| idx_ready | output | 1 | Index accepted this cycle when valid |
| clu_ready | input | N_CLU | Cluster can take a batch |
| out_valid | output | 1 | Batch word valid |
| out_dest | output | N_CLU | One-hot target cluster of the batch |
| out_is_tri | output | 1 | Word is a triangle word |
| out_vtx | output | IDX_W | Vertex index of a vertex word |
| out_tri | output | 3*SLOT_W | Corner slots of a triangle word |
| out_last | output | 1 | Final word of the batch |

## Verification
The bench runs several input patterns:
- Triangles with shared corners show that reuse works and that slots point to the right words.
- Fully distinct triangles fill the vertex budget at ten triangles, which tests the vertex-driven close.
- Triangles that repeat the same three indices fill the triangle budget at 32 with only three vertices, which tests the triangle-driven close.
- Degenerate triangles with repeated corners show that duplicates inside one triangle are merged.
- A generated draw shows that the built-in index source matches an equivalent indexed stream.

Changing the ready masks between draws separates a round-robin choice from a fixed-priority one. A draw that ends partway through a triangle, and one that ends with no triangle at all, test the flush rules.

// File: rtl/pbat_pkg.sv
package pbat_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_COMMIT,
        ST_GRANT,
        ST_EMIT
    } bat_state_e;

endpackage

// File: rtl/pbat_source.sv
module pbat_source #(
    parameter int IDX_W = 16,
    parameter int TRI_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gen_start,
    input  logic [IDX_W-1:0] gen_first,
    input  logic [TRI_W-1:0] gen_tris,
    input  logic             ext_valid,
    input  logic [IDX_W-1:0] ext_idx,
    input  logic             ext_last,
    output logic             ext_ready,
    output logic             s_valid,
    output logic [IDX_W-1:0] s_idx,
    output logic             s_last,
    input  logic             s_ready
);
    localparam int REM_W = TRI_W + 2;

    logic             active_q;
    logic [IDX_W-1:0] cur_q;
    logic [REM_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cur_q    <= '0;
            remain_q <= '0;
        end else if (!active_q && gen_start && gen_tris != '0) begin
            active_q <= 1'b1;
            cur_q    <= gen_first;
            remain_q <= {2'b00, gen_tris} + {1'b0, gen_tris, 1'b0};
        end else if (active_q && s_ready) begin
            cur_q    <= cur_q + 1'b1;
            remain_q <= remain_q - 1'b1;
            if (remain_q == REM_W'(1))
                active_q <= 1'b0;
        end
    end

    always_comb begin
        s_valid   = active_q ? 1'b1 : ext_valid;
        s_idx     = active_q ? cur_q : ext_idx;
        s_last    = active_q ? (remain_q == REM_W'(1)) : ext_last;
        ext_ready = !active_q && s_ready;
    end

    // consecutive generated indices step by one
    p_gen_seq_r1: assert property (@(posedge clk) disable iff (rst)
        (active_q && s_ready && remain_q != REM_W'(1)) |=> (s_idx == $past(s_idx) + 1'b1));

endmodule

// File: rtl/pbat_cam.sv
module pbat_cam #(
    parameter int IDX_W  = 16,
    parameter int DEPTH  = 32,
    parameter int SLOT_W = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic [2:0][IDX_W-1:0]       look_key,
    output logic [2:0]                  hit,
    output logic [2:0][SLOT_W-1:0]      hit_slot,
    input  logic [2:0]                  wr_en,
    input  logic [2:0][SLOT_W-1:0]      wr_slot,
    input  logic [SLOT_W-1:0]           rd_slot,
    output logic [IDX_W-1:0]            rd_key
);
    logic [IDX_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            hit[k]      = 1'b0;
            hit_slot[k] = '0;
            for (int e = 0; e < DEPTH; e++) begin
                if (vld_q[e] && key_q[e] == look_key[k]) begin
                    hit[k]      = 1'b1;
                    hit_slot[k] = SLOT_W'(e);
                end
            end
        end
    end

    assign rd_key = key_q[rd_slot];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vld_q <= '0;
        end else begin
            for (int k = 0; k < 3; k++)
                if (wr_en[k]) vld_q[wr_slot[k]] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < 3; k++)
            if (wr_en[k]) key_q[wr_slot[k]] <= look_key[k];
    end

    generate
        for (genvar k = 0; k < 3; k++) begin : g_chk
            // a new vertex lands in a free slot and was not already present
            p_fresh_slot_r3: assert property (@(posedge clk) disable iff (rst)
                wr_en[k] |-> (!vld_q[wr_slot[k]] && !hit[k]));
        end
    endgenerate

endmodule

// File: rtl/pbat_arb.sv
module pbat_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ready,
    input  logic         take,
    output logic         any_ready,
    output logic [N-1:0] grant_oh
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] pick;
    logic             found;

    always_comb begin
        int c;
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= N; i++) begin
            c = (int'(ptr_q) + i) % N;
            if (!found && ready[c]) begin
                found = 1'b1;
                pick  = PTR_W'(c);
            end
        end
        any_ready = found;
        grant_oh  = found ? (N'(1) << pick) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= PTR_W'(N - 1);
        else if (take) ptr_q <= pick;
    end

    p_take_ready_r8: assert property (@(posedge clk) disable iff (rst)
        take |-> ($onehot(grant_oh) && (grant_oh & ready) != '0));

endmodule

// File: rtl/prim_batcher.sv
module prim_batcher
    import pbat_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int TRI_W   = 16,
    parameter int N_CLU   = 4,
    parameter int VTX_MAX = 32,
    parameter int TRI_MAX = 32,
    parameter int SLOT_W  = $clog2(VTX_MAX)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  gen_start,
    input  logic [IDX_W-1:0]      gen_first,
    input  logic [TRI_W-1:0]      gen_tris,
    input  logic                  idx_valid,
    input  logic [IDX_W-1:0]      idx_data,
    input  logic                  idx_last,
    output logic                  idx_ready,
    input  logic [N_CLU-1:0]      clu_ready,
    output logic                  out_valid,
    output logic [N_CLU-1:0]      out_dest,
    output logic                  out_is_tri,
    output logic [IDX_W-1:0]      out_vtx,
    output logic [3*SLOT_W-1:0]   out_tri,
    output logic                  out_last
);
    localparam int VCNT_W  = $clog2(VTX_MAX + 1);
    localparam int TCNT_W  = $clog2(TRI_MAX + 1);
    localparam int TSLOT_W = $clog2(TRI_MAX);
    localparam int WORD_W  = $clog2(VTX_MAX + TRI_MAX + 1);

    bat_state_e state_q;

    logic             s_valid, s_last, s_ready;
    logic [IDX_W-1:0] s_idx;

    logic [2:0][IDX_W-1:0]  key_q;
    logic [1:0]             col_q;
    logic                   last_q, pend_q;
    logic [VCNT_W-1:0]      vcnt_q;
    logic [TCNT_W-1:0]      tcnt_q;
    logic [WORD_W-1:0]      word_q;
    logic [N_CLU-1:0]       dest_q;
    logic [3*SLOT_W-1:0]    tri_mem [TRI_MAX];

    logic [2:0]              hit, isnew, wr_en;
    logic [2:0][SLOT_W-1:0]  hit_slot, slot;
    logic [VCNT_W:0]         new_n;
    logic                    fits, commit_go, take, any_ready, clear;
    logic [N_CLU-1:0]        grant_oh;
    logic [IDX_W-1:0]        rd_key;
    logic [WORD_W-1:0]       total, tidx;

    pbat_source #(.IDX_W(IDX_W), .TRI_W(TRI_W)) i_src (
        .clk(clk), .rst(rst),
        .gen_start(gen_start), .gen_first(gen_first), .gen_tris(gen_tris),
        .ext_valid(idx_valid), .ext_idx(idx_data), .ext_last(idx_last),
        .ext_ready(idx_ready),
        .s_valid(s_valid), .s_idx(s_idx), .s_last(s_last), .s_ready(s_ready)
    );

    pbat_cam #(.IDX_W(IDX_W), .DEPTH(VTX_MAX), .SLOT_W(SLOT_W)) i_cam (
        .clk(clk), .rst(rst), .clear(clear),
        .look_key(key_q), .hit(hit), .hit_slot(hit_slot),
        .wr_en(wr_en), .wr_slot(slot),
        .rd_slot(word_q[SLOT_W-1:0]), .rd_key(rd_key)
    );

    pbat_arb #(.N(N_CLU)) i_arb (
        .clk(clk), .rst(rst), .ready(clu_ready), .take(take),
        .any_ready(any_ready), .grant_oh(grant_oh)
    );

    // corner dedup and slot assignment for the held triangle
    always_comb begin
        logic [VCNT_W-1:0] base1, base2;
        isnew[0] = !hit[0];
        isnew[1] = !hit[1] && (key_q[1] != key_q[0]);
        isnew[2] = !hit[2] && (key_q[2] != key_q[0]) && (key_q[2] != key_q[1]);
        new_n = (VCNT_W+1)'(isnew[0]) + (VCNT_W+1)'(isnew[1]) + (VCNT_W+1)'(isnew[2]);
        base1 = vcnt_q + VCNT_W'(isnew[0]);
        base2 = base1 + VCNT_W'(isnew[1]);
        slot[0] = hit[0] ? hit_slot[0] : vcnt_q[SLOT_W-1:0];
        slot[1] = hit[1] ? hit_slot[1] :
                  (key_q[1] == key_q[0]) ? slot[0] : base1[SLOT_W-1:0];
        slot[2] = hit[2] ? hit_slot[2] :
                  (key_q[2] == key_q[0]) ? slot[0] :
                  (key_q[2] == key_q[1]) ? slot[1] : base2[SLOT_W-1:0];
        fits = (tcnt_q < TCNT_W'(TRI_MAX)) &&
               ({1'b0, vcnt_q} + new_n <= (VCNT_W+1)'(VTX_MAX));
    end

    assign commit_go = (state_q == ST_COMMIT) && fits;
    assign wr_en     = commit_go ? isnew : 3'b000;
    assign s_ready   = (state_q == ST_COLLECT);
    assign take      = (state_q == ST_GRANT) && any_ready;
    assign total     = WORD_W'(vcnt_q) + WORD_W'(tcnt_q);
    assign clear     = (state_q == ST_EMIT) && (word_q == total - 1'b1);
    assign tidx      = word_q - WORD_W'(vcnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_COLLECT;
            key_q   <= '0;
            col_q   <= '0;
            last_q  <= 1'b0;
            pend_q  <= 1'b0;
            vcnt_q  <= '0;
            tcnt_q  <= '0;
            word_q  <= '0;
            dest_q  <= '0;
        end else begin
            unique case (state_q)
                ST_COLLECT: if (s_valid) begin
                    key_q[col_q] <= s_idx;
                    if (col_q == 2'd2) begin
                        col_q   <= '0;
                        last_q  <= s_last;
                        state_q <= ST_COMMIT;
                    end else if (s_last) begin
                        col_q  <= '0;
                        pend_q <= 1'b0;
                        if (tcnt_q != '0) state_q <= ST_GRANT;
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                ST_COMMIT: begin
                    if (fits) begin
                        vcnt_q  <= vcnt_q + new_n[VCNT_W-1:0];
                        tcnt_q  <= tcnt_q + 1'b1;
                        pend_q  <= 1'b0;
                        state_q <= last_q ? ST_GRANT : ST_COLLECT;
                    end else begin
                        pend_q  <= 1'b1;
                        state_q <= ST_GRANT;
                    end
                end
                ST_GRANT: if (any_ready) begin
                    dest_q  <= grant_oh;
                    word_q  <= '0;
                    state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    word_q <= word_q + 1'b1;
                    if (clear) begin
                        vcnt_q  <= '0;
                        tcnt_q  <= '0;
                        state_q <= pend_q ? ST_COMMIT : ST_COLLECT;
                    end
                end
                default: state_q <= ST_COLLECT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (commit_go)
            tri_mem[tcnt_q[TSLOT_W-1:0]] <= {slot[2], slot[1], slot[0]};
    end

    always_comb begin
        out_valid  = (state_q == ST_EMIT);
        out_is_tri = word_q >= WORD_W'(vcnt_q);
        out_vtx    = rd_key;
        out_tri    = tri_mem[tidx[TSLOT_W-1:0]];
        out_last   = clear;
        out_dest   = out_valid ? dest_q : '0;
    end

    p_caps_r2: assert property (@(posedge clk) disable iff (rst)
        (vcnt_q <= VCNT_W'(VTX_MAX)) && (tcnt_q <= TCNT_W'(TRI_MAX)));

    p_no_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GRANT) |-> (tcnt_q != '0));

    p_dest_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> (out_valid && $stable(out_dest)));

    p_dest_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot(out_dest));

    p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_tri) |->
            ((VCNT_W'(out_tri[SLOT_W-1:0]) < vcnt_q) &&
             (VCNT_W'(out_tri[2*SLOT_W-1:SLOT_W]) < vcnt_q) &&
             (VCNT_W'(out_tri[3*SLOT_W-1:2*SLOT_W]) < vcnt_q)));

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GRANT && clu_ready == '0) |=> (!out_valid && !idx_ready));

endmodule

// File: tb/test_prim_batcher.sv
module test_prim_batcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gen_start = 1'b0;
    logic [15:0] gen_first = '0;
    logic [15:0] gen_tris = '0;
    logic        idx_valid = 1'b0;
    logic [15:0] idx_data = '0;
    logic        idx_last = 1'b0;
    logic        idx_ready;
    logic [3:0]  clu_ready = 4'b1111;
    logic        out_valid;
    logic [3:0]  out_dest;
    logic        out_is_tri;
    logic [15:0] out_vtx;
    logic [14:0] out_tri;
    logic        out_last;

    always #4 clk = ~clk;

    prim_batcher i_prim_batcher (
        .clk(clk), .rst(rst),
        .gen_start(gen_start), .gen_first(gen_first), .gen_tris(gen_tris),
        .idx_valid(idx_valid), .idx_data(idx_data), .idx_last(idx_last),
        .idx_ready(idx_ready), .clu_ready(clu_ready),
        .out_valid(out_valid), .out_dest(out_dest), .out_is_tri(out_is_tri),
        .out_vtx(out_vtx), .out_tri(out_tri), .out_last(out_last)
    );

    typedef struct packed {
        logic        is_tri;
        logic [31:0] data;
        logic        last;
        logic [3:0]  dest;
    } exp_t;

    exp_t  eq[$];
    int    mv[$];
    int    mt[$];
    int    rr_ptr = 3;
    logic [3:0] mmask = 4'b1111;
    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    done = 1'b0;
    int    seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference: send the current batch to the next ready cluster
    task automatic m_flush();
        int d;
        exp_t e;
        if (mt.size() == 0) return;
        d = rr_ptr;
        for (int i = 1; i <= 4; i++) begin
            int c;
            c = (rr_ptr + i) % 4;
            if (mmask[c]) begin d = c; break; end
        end
        rr_ptr = d;
        for (int i = 0; i < mv.size(); i++) begin
            e.is_tri = 1'b0; e.data = mv[i]; e.dest = 4'(1 << d);
            e.last = (mt.size() == 0);
            eq.push_back(e);
        end
        for (int i = 0; i < mt.size(); i++) begin
            e.is_tri = 1'b1; e.data = mt[i]; e.dest = 4'(1 << d);
            e.last = (i == mt.size() - 1);
            eq.push_back(e);
        end
        mv.delete();
        mt.delete();
    endtask

    function automatic int m_find(input int x);
        for (int i = 0; i < mv.size(); i++) if (mv[i] == x) return i;
        return -1;
    endfunction

    task automatic m_tri(input int a, input int b, input int c);
        int nv[$];
        int cs[3];
        int w;
        cs[0] = a; cs[1] = b; cs[2] = c;
        for (int k = 0; k < 3; k++) begin
            bit dup;
            dup = (m_find(cs[k]) >= 0);
            foreach (nv[j]) if (nv[j] == cs[k]) dup = 1'b1;
            if (!dup) nv.push_back(cs[k]);
        end
        if (mt.size() == 32 || mv.size() + nv.size() > 32) m_flush();
        w = 0;
        for (int k = 0; k < 3; k++) begin
            if (m_find(cs[k]) < 0) mv.push_back(cs[k]);
            w = w | (m_find(cs[k]) << (5 * k));
        end
        mt.push_back(w);
    endtask

    task automatic send(input int v, input bit last);
        @(negedge clk);
        idx_valid = 1'b1; idx_data = 16'(v); idx_last = last;
        while (!idx_ready) @(negedge clk);
        @(posedge clk);
        #1;
        idx_valid = 1'b0; idx_last = 1'b0;
    endtask

    task automatic tri_in(input int a, input int b, input int c, input bit last);
        m_tri(a, b, c);
        if (last) m_flush();
        send(a, 1'b0);
        send(b, 1'b0);
        send(c, last);
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (eq.size() != 0 && t < 5000) begin @(negedge clk); t++; end
        check(t < 5000, cur_req, "words still expected after wait", eq.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    // word monitor against the reference
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            seen++;
            if (eq.size() == 0) begin
                check(1'b0, cur_req, "unexpected output word (R6 R9)", 1, 0);
            end else begin
                exp_t e;
                int act;
                e = eq.pop_front();
                act = out_is_tri ? int'(out_tri) : int'(out_vtx);
                check(out_is_tri == e.is_tri, cur_req, "word kind R7", out_is_tri, e.is_tri);
                check(act == int'(e.data), cur_req,
                      e.is_tri ? "triangle slots R4" : "vertex index R3", act, e.data);
                check(out_last == e.last, cur_req, "last flag R7", out_last, e.last);
                check(out_dest == e.dest, cur_req, "target cluster R8", out_dest, e.dest);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(out_dest == 4'b0, "R10", "out_dest after reset", out_dest, 0);
        check(idx_ready == 1'b1, "R10", "idx_ready after reset", idx_ready, 1);

        // R3 R4: shared corners reused
        cur_req = "R3";
        tri_in(0, 1, 2, 1'b0);
        tri_in(2, 1, 3, 1'b1);
        drain();

        // R5 R2: distinct triangles fill the vertex budget at 10
        cur_req = "R5";
        for (int t = 0; t < 40; t++) tri_in(200 + 3*t, 201 + 3*t, 202 + 3*t, t == 39);
        drain();

        // R2 R5: same three corners fill the triangle budget at 32
        cur_req = "R2";
        for (int t = 0; t < 40; t++) tri_in(7, 8, 9, t == 39);
        drain();

        // R3: degenerate corners merge
        cur_req = "R3";
        tri_in(5, 5, 5, 1'b0);
        tri_in(6, 5, 6, 1'b1);
        drain();

        // R8: round robin over a sparse mask
        cur_req = "R8";
        clu_ready = 4'b1010; mmask = 4'b1010;
        for (int t = 0; t < 25; t++) tri_in(400 + 3*t, 401 + 3*t, 402 + 3*t, t == 24);
        drain();
        clu_ready = 4'b1111; mmask = 4'b1111;

        // R1: generated draw, external stream held off
        cur_req = "R1";
        for (int t = 0; t < 12; t++) m_tri(100 + 3*t, 101 + 3*t, 102 + 3*t);
        m_flush();
        @(negedge clk);
        gen_first = 16'd100; gen_tris = 16'd12; gen_start = 1'b1;
        @(negedge clk);
        gen_start = 1'b0;
        check(idx_ready == 1'b0, "R1", "idx_ready during generation", idx_ready, 0);
        gen_first = 16'd900; gen_tris = 16'd3; gen_start = 1'b1;
        @(negedge clk);
        gen_start = 1'b0;
        drain();
        check(idx_ready == 1'b1, "R1", "idx_ready after generation", idx_ready, 1);

        // R6: trailing partial triangle dropped, empty draw sends nothing
        cur_req = "R6";
        tri_in(30, 31, 32, 1'b0);
        m_flush();
        send(33, 1'b1);
        drain();
        seen = 0;
        send(34, 1'b1);
        repeat (30) @(negedge clk);
        check(seen == 0, "R6", "words sent for empty draw", seen, 0);

        // R9: stall with no ready cluster
        cur_req = "R9";
        clu_ready = 4'b0000; mmask = 4'b0100;
        seen = 0;
        tri_in(50, 51, 52, 1'b1);
        repeat (20) @(negedge clk);
        check(seen == 0, "R9", "words sent while no cluster ready", seen, 0);
        check(idx_ready == 1'b0, "R9", "idx_ready while stalled", idx_ready, 0);
        clu_ready = 4'b0100;
        drain();
        check(seen == 4, "R9", "words after release", seen, 4);
        clu_ready = 4'b1111; mmask = 4'b1111;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule